// File: doc/BRIEF.md
# Register Rename Stage with Recycling Free Pool

This block is the renaming step of an out-of-order core. It maps a small set of architectural register names onto a larger set of physical registers. Each cycle it accepts a group of up to `W` decoded instructions, given in program order, and answers in the same cycle. For each source operand it returns the physical name that holds the value. For each destination it returns a newly allocated physical name and the physical name that the destination was mapped to before. It holds two tables: a speculative map, which advances as instructions are renamed, and a committed map, which advances as instructions retire.

Retirement copies no data. A commit points the committed entry for the destination at the instruction's physical register. The physical register that the committed entry held until then goes back to the free pool. The free pool is a FIFO of physical register indices. A squash therefore needs no list of the discarded registers: the pool's read position moves back to the position of the oldest allocation that has not committed, and the speculative map is overwritten with the committed map. A new instruction can enter only if a spare physical register is free, so the spare count limits how many instructions are in flight.

Commits arrive one per cycle, in the same order as the allocations. The number of spare registers (`NP - NL`) must be a power of two.

Top module: `rn_top`

## Requirements
- R1: After reset, logical register n (0 to 31) maps to physical register n in both maps. The free pool holds physical registers 32 to 63 in ascending order, and 32 is handed out first.
- R2: Each source operand is translated through the speculative map combinationally, so the answer appears in the same cycle as the request.
- R3: Lanes whose valid bit is set take physical registers from the head of the pool, in lane order, counting only valid lanes. An accepted group moves each destination's speculative entry to its new register. A newly allocated register is never one that the committed map holds.
- R4: `ren_pold` gives the mapping that a lane's destination had before that lane renamed it.
- R5: Within a group, a lane's sources and its previous-mapping output see the new register of the latest earlier valid lane with the same logical destination. Invalid lanes do not take part in this forwarding.
- R6: If the group has more valid lanes than the pool has free registers, `ren_stall` is high and the whole group is refused. The speculative map and the pool stay unchanged.
- R7: A commit sets the committed entry of `cmt_log` to `cmt_phys` and appends the register displaced from that entry to the tail of the pool. A register freed in a cycle cannot be allocated in that same cycle.
- R8: On `flush`, the speculative map becomes the committed map and every register held by an uncommitted instruction returns to the pool, with the oldest at the head. Rename requests in the flush cycle are not accepted.
- R9: Registers freed by commits are allocated again in the order in which they were freed, after the registers that were already in the pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ren_valid | input | W | Valid bit per rename lane; lane 0 is the oldest |
| ren_dst | input | W x 5 | Logical destination per lane |
| ren_srca | input | W x 5 | First logical source per lane |
| ren_srcb | input | W x 5 | Second logical source per lane |
| ren_fire | output | 1 | The group is accepted this cycle |
| ren_stall | output | 1 | Not enough free registers for the group |
| ren_pa | output | W x 6 | Physical name of the first source |
| ren_pb | output | W x 6 | Physical name of the second source |
| ren_pdst | output | W x 6 | Newly allocated physical destination |
| ren_pold | output | W x 6 | Previous physical mapping of the destination |
| cmt_valid | input | 1 | Commit of the oldest renamed instruction |
| cmt_log | input | 5 | Logical destination of the committing instruction |
| cmt_phys | input | 6 | Physical register of the committing instruction |
| flush | input | 1 | Squash all uncommitted instructions |

## Verification
The hardest state to reach from the ports is an empty pool at the same moment as a commit: the freed register must stay unavailable for one cycle and must then come out before anything else. The stimulus first commits two instructions and flushes, which rewinds the pool past the squashed allocations. It then renames full groups until the pool runs dry, so that the commits that follow land on an empty pool, and a two-lane request is made while only one register is free. The vector table covers forwarding within a group, including an invalid earlier lane that must not forward and an earlier lane that renames the same destination twice.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int RN_NL = 32;   // logical registers
    localparam int RN_NP = 64;   // physical registers
    localparam int RN_W  = 2;    // rename lanes per cycle

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
    parameter int NL = rn_pkg::RN_NL,
    parameter int NP = rn_pkg::RN_NP,
    parameter int W  = rn_pkg::RN_W,
    localparam int DEPTH = NP - NL,
    localparam int IW    = rn_pkg::idx_bits(NP),
    localparam int PW    = rn_pkg::idx_bits(DEPTH) + 1,
    localparam int CW    = rn_pkg::idx_bits(W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CW-1:0]        pop_n,
    input  logic                 push_en,
    input  logic [IW-1:0]        push_idx,
    input  logic                 flush,
    output logic [W-1:0][IW-1:0] head_idx,
    output logic [PW-1:0]        avail
);
    typedef struct packed {
        logic [DEPTH-1:0][IW-1:0] slot;
        logic [PW-1:0]            hd;   // next entry to allocate
        logic [PW-1:0]            tl;   // next entry to fill
        logic [PW-1:0]            chd;  // head as seen by committed state
    } fl_t;

    fl_t fl_q, fl_d;

    function automatic fl_t fl_reset();
        fl_t r;
        for (int i = 0; i < DEPTH; i++) r.slot[i] = IW'(NL + i);
        r.hd  = '0;
        r.chd = '0;
        r.tl  = PW'(DEPTH);
        return r;
    endfunction

    always_comb begin
        fl_d = fl_q;
        for (int i = 0; i < W; i++) begin
            head_idx[i] = fl_q.slot[fl_q.hd[PW-2:0] + (PW-1)'(i)];
        end
        avail = fl_q.tl - fl_q.hd;
        fl_d.hd = fl_q.hd + PW'(pop_n);
        if (push_en) begin
            fl_d.slot[fl_q.tl[PW-2:0]] = push_idx;
            fl_d.tl  = fl_q.tl + 1'b1;
            fl_d.chd = fl_q.chd + 1'b1;
        end
        if (flush) fl_d.hd = fl_d.chd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= fl_reset();
        else        fl_q <= fl_d;
    end
endmodule

// File: rtl/rn_maptable.sv
module rn_maptable #(
    parameter int NL = rn_pkg::RN_NL,
    parameter int NP = rn_pkg::RN_NP,
    parameter int W  = rn_pkg::RN_W,
    localparam int LW = rn_pkg::idx_bits(NL),
    localparam int IW = rn_pkg::idx_bits(NP)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [W-1:0]          wr_en,
    input  logic [W-1:0][LW-1:0]  wr_log,
    input  logic [W-1:0][IW-1:0]  wr_phys,
    input  logic                  cm_en,
    input  logic [LW-1:0]         cm_log,
    input  logic [IW-1:0]         cm_phys,
    input  logic                  flush,
    output logic [NL-1:0][IW-1:0] smap,
    output logic [NL-1:0][IW-1:0] cmap,
    output logic [IW-1:0]         cm_old
);
    typedef struct packed {
        logic [NL-1:0][IW-1:0] spec;
        logic [NL-1:0][IW-1:0] comm;
    } map_t;

    map_t map_q, map_d;

    function automatic map_t map_reset();
        map_t r;
        for (int i = 0; i < NL; i++) begin
            r.spec[i] = IW'(i);
            r.comm[i] = IW'(i);
        end
        return r;
    endfunction

    always_comb begin
        map_d = map_q;
        for (int i = 0; i < W; i++) begin
            if (wr_en[i]) map_d.spec[wr_log[i]] = wr_phys[i];
        end
        if (cm_en) map_d.comm[cm_log] = cm_phys;
        if (flush) map_d.spec = map_d.comm;
    end

    assign smap   = map_q.spec;
    assign cmap   = map_q.comm;
    assign cm_old = map_q.comm[cm_log];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) map_q <= map_reset();
        else        map_q <= map_d;
    end
endmodule

// File: rtl/rn_xlate.sv
module rn_xlate #(
    parameter int NL = rn_pkg::RN_NL,
    parameter int NP = rn_pkg::RN_NP,
    parameter int W  = rn_pkg::RN_W,
    localparam int LW = rn_pkg::idx_bits(NL),
    localparam int IW = rn_pkg::idx_bits(NP),
    localparam int PW = rn_pkg::idx_bits(NP - NL) + 1,
    localparam int CW = rn_pkg::idx_bits(W + 1),
    localparam int SW = rn_pkg::idx_bits(W)
) (
    input  logic [NL-1:0][IW-1:0] smap,
    input  logic [W-1:0]          valid,
    input  logic [W-1:0][LW-1:0]  dst,
    input  logic [W-1:0][LW-1:0]  srca,
    input  logic [W-1:0][LW-1:0]  srcb,
    input  logic [W-1:0][IW-1:0]  head_idx,
    input  logic [PW-1:0]         avail,
    input  logic                  flush,
    output logic [W-1:0][IW-1:0]  pa,
    output logic [W-1:0][IW-1:0]  pb,
    output logic [W-1:0][IW-1:0]  pd,
    output logic [W-1:0][IW-1:0]  po,
    output logic                  stall,
    output logic                  fire,
    output logic [CW-1:0]         pop_n,
    output logic [W-1:0]          wr_en
);
    logic [CW-1:0] need;
    logic [SW-1:0] run;

    always_comb begin
        need  = CW'($countones(valid));
        stall = (PW'(need) > avail);
        fire  = (|valid) && !stall && !flush;
        pop_n = fire ? need : '0;
        wr_en = fire ? valid : '0;
        run   = '0;
        for (int i = 0; i < W; i++) begin
            pd[i] = head_idx[run];
            if (valid[i]) run = run + 1'b1;
            pa[i] = smap[srca[i]];
            pb[i] = smap[srcb[i]];
            po[i] = smap[dst[i]];
            // later lanes override earlier ones: the youngest producer wins
            for (int j = 0; j < i; j++) begin
                if (valid[j] && dst[j] == srca[i]) pa[i] = pd[j];
                if (valid[j] && dst[j] == srcb[i]) pb[i] = pd[j];
                if (valid[j] && dst[j] == dst[i])  po[i] = pd[j];
            end
        end
    end
endmodule

// File: rtl/rn_top.sv
module rn_top #(
    parameter int NL = rn_pkg::RN_NL,
    parameter int NP = rn_pkg::RN_NP,
    parameter int W  = rn_pkg::RN_W,
    localparam int LW = rn_pkg::idx_bits(NL),
    localparam int IW = rn_pkg::idx_bits(NP),
    localparam int PW = rn_pkg::idx_bits(NP - NL) + 1,
    localparam int CW = rn_pkg::idx_bits(W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W-1:0]         ren_valid,
    input  logic [W-1:0][LW-1:0] ren_dst,
    input  logic [W-1:0][LW-1:0] ren_srca,
    input  logic [W-1:0][LW-1:0] ren_srcb,
    output logic                 ren_fire,
    output logic                 ren_stall,
    output logic [W-1:0][IW-1:0] ren_pa,
    output logic [W-1:0][IW-1:0] ren_pb,
    output logic [W-1:0][IW-1:0] ren_pdst,
    output logic [W-1:0][IW-1:0] ren_pold,
    input  logic                 cmt_valid,
    input  logic [LW-1:0]        cmt_log,
    input  logic [IW-1:0]        cmt_phys,
    input  logic                 flush
);
    logic [NL-1:0][IW-1:0] smap;
    logic [NL-1:0][IW-1:0] cmap;
    logic [IW-1:0]         cm_old;
    logic [W-1:0][IW-1:0]  head_idx;
    logic [PW-1:0]         avail;
    logic [CW-1:0]         pop_n;
    logic [W-1:0]          wr_en;

    rn_freelist #(.NL(NL), .NP(NP), .W(W)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop_n    (pop_n),
        .push_en  (cmt_valid),
        .push_idx (cm_old),
        .flush    (flush),
        .head_idx (head_idx),
        .avail    (avail)
    );

    rn_maptable #(.NL(NL), .NP(NP), .W(W)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_log  (ren_dst),
        .wr_phys (ren_pdst),
        .cm_en   (cmt_valid),
        .cm_log  (cmt_log),
        .cm_phys (cmt_phys),
        .flush   (flush),
        .smap    (smap),
        .cmap    (cmap),
        .cm_old  (cm_old)
    );

    rn_xlate #(.NL(NL), .NP(NP), .W(W)) u_xl (
        .smap     (smap),
        .valid    (ren_valid),
        .dst      (ren_dst),
        .srca     (ren_srca),
        .srcb     (ren_srcb),
        .head_idx (head_idx),
        .avail    (avail),
        .flush    (flush),
        .pa       (ren_pa),
        .pb       (ren_pb),
        .pd       (ren_pdst),
        .po       (ren_pold),
        .stall    (ren_stall),
        .fire     (ren_fire),
        .pop_n    (pop_n),
        .wr_en    (wr_en)
    );
endmodule

// File: rtl/rn_chk.sv
module rn_chk #(
    parameter int NL = rn_pkg::RN_NL,
    parameter int NP = rn_pkg::RN_NP,
    parameter int W  = rn_pkg::RN_W,
    localparam int LW = rn_pkg::idx_bits(NL),
    localparam int IW = rn_pkg::idx_bits(NP)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [W-1:0]          ren_valid,
    input logic [W-1:0][LW-1:0]  ren_dst,
    input logic                  ren_fire,
    input logic                  ren_stall,
    input logic [W-1:0][IW-1:0]  ren_pdst,
    input logic                  cmt_valid,
    input logic [LW-1:0]         cmt_log,
    input logic [IW-1:0]         cmt_phys,
    input logic                  flush,
    input logic [NL-1:0][IW-1:0] smap,
    input logic [NL-1:0][IW-1:0] cmap
);
    logic alloc_hit;
    logic alloc_dup;

    always_comb begin
        alloc_hit = 1'b0;
        alloc_dup = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (ren_fire && ren_valid[i]) begin
                for (int k = 0; k < NL; k++) begin
                    if (cmap[k] == ren_pdst[i]) alloc_hit = 1'b1;
                end
                for (int j = 0; j < i; j++) begin
                    if (ren_valid[j] && ren_pdst[j] == ren_pdst[i]) alloc_dup = 1'b1;
                end
            end
        end
    end

    assert_fresh_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_hit);

    assert_unique_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_dup);

    assert_spec_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_fire && ren_valid[W-1]) |=>
            smap[$past(ren_dst[W-1])] == $past(ren_pdst[W-1]));

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_stall && !flush) |=> smap == $past(smap));

    assert_commit_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |=> cmap[$past(cmt_log)] == $past(cmt_phys));

    assert_flush_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> smap == cmap);
endmodule

bind rn_top rn_chk #(.NL(NL), .NP(NP), .W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ren_valid (ren_valid),
    .ren_dst   (ren_dst),
    .ren_fire  (ren_fire),
    .ren_stall (ren_stall),
    .ren_pdst  (ren_pdst),
    .cmt_valid (cmt_valid),
    .cmt_log   (cmt_log),
    .cmt_phys  (cmt_phys),
    .flush     (flush),
    .smap      (smap),
    .cmap      (cmap)
);

// File: tb/sim_rn_top.sv
module sim_rn_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]      ren_valid;
    logic [1:0][4:0] ren_dst, ren_srca, ren_srcb;
    logic            ren_fire, ren_stall;
    logic [1:0][5:0] ren_pa, ren_pb, ren_pdst, ren_pold;
    logic            cmt_valid;
    logic [4:0]      cmt_log;
    logic [5:0]      cmt_phys;
    logic            flush;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rn_top u0 (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_dst(ren_dst), .ren_srca(ren_srca), .ren_srcb(ren_srcb),
        .ren_fire(ren_fire), .ren_stall(ren_stall),
        .ren_pa(ren_pa), .ren_pb(ren_pb), .ren_pdst(ren_pdst), .ren_pold(ren_pold),
        .cmt_valid(cmt_valid), .cmt_log(cmt_log), .cmt_phys(cmt_phys), .flush(flush)
    );

    typedef struct packed {
        logic [1:0] v;
        logic [4:0] d0, a0, b0, d1, a1, b1;
        logic [5:0] pa0, pb0, pd0, po0, pa1, pb1, pd1, po1;
    } vec_t;

    // rename groups applied from reset; expected names follow R1..R5
    localparam vec_t VECS [5] = '{
        '{2'b11, 5'd1, 5'd2, 5'd3,  5'd4, 5'd1, 5'd5,   6'd2, 6'd3, 6'd32, 6'd1,   6'd32, 6'd5, 6'd33, 6'd4},
        '{2'b11, 5'd1, 5'd1, 5'd4,  5'd1, 5'd1, 5'd0,   6'd32, 6'd33, 6'd34, 6'd32, 6'd34, 6'd0, 6'd35, 6'd34},
        '{2'b01, 5'd7, 5'd7, 5'd1,  5'd9, 5'd9, 5'd9,   6'd7, 6'd35, 6'd36, 6'd7,   6'd0, 6'd0, 6'd0, 6'd0},
        '{2'b10, 5'd4, 5'd0, 5'd0,  5'd2, 5'd4, 5'd7,   6'd0, 6'd0, 6'd0, 6'd0,     6'd33, 6'd36, 6'd37, 6'd2},
        '{2'b11, 5'd31, 5'd31, 5'd2, 5'd0, 5'd31, 5'd31, 6'd31, 6'd37, 6'd38, 6'd31, 6'd38, 6'd38, 6'd39, 6'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // inputs change at the falling edge; outputs are sampled 5 ns later
    task automatic drive(input logic [1:0] v, input logic [4:0] d0, a0, b0, d1, a1, b1,
                         input logic cv, input logic [4:0] cl, input logic [5:0] cp,
                         input logic fl);
        @(negedge clk);
        ren_valid = v;
        ren_dst[0] = d0; ren_srca[0] = a0; ren_srcb[0] = b0;
        ren_dst[1] = d1; ren_srca[1] = a1; ren_srcb[1] = b1;
        cmt_valid = cv; cmt_log = cl; cmt_phys = cp; flush = fl;
        #5;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got 1 expected 0");
        finish_run();
    end

    initial begin
        ren_valid = '0; ren_dst = '0; ren_srca = '0; ren_srcb = '0;
        cmt_valid = 1'b0; cmt_log = '0; cmt_phys = '0; flush = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1/R2: identity map and pool head after reset
        drive(2'b00, 5'd0, 5'd10, 5'd20, 5'd0, 5'd31, 5'd0, 1'b0, 5'd0, 6'd0, 1'b0);
        chk("R1 pa lane0", ren_pa[0], 10);
        chk("R1 pb lane0", ren_pb[0], 20);
        chk("R2 pa lane1", ren_pa[1], 31);
        chk("R1 pool head", ren_pdst[0], 32);
        chk("R1 no fire when idle", ren_fire, 0);
        chk("R1 no stall", ren_stall, 0);

        // R2..R5 table walk
        for (int r = 0; r < 5; r++) begin
            drive(VECS[r].v, VECS[r].d0, VECS[r].a0, VECS[r].b0,
                  VECS[r].d1, VECS[r].a1, VECS[r].b1, 1'b0, 5'd0, 6'd0, 1'b0);
            chk("R3 group accepted", ren_fire, 1);
            if (VECS[r].v[0]) begin
                chk("R2 lane0 srca", ren_pa[0], VECS[r].pa0);
                chk("R2 lane0 srcb", ren_pb[0], VECS[r].pb0);
                chk("R3 lane0 dst", ren_pdst[0], VECS[r].pd0);
                chk("R4 lane0 old", ren_pold[0], VECS[r].po0);
            end
            if (VECS[r].v[1]) begin
                chk("R5 lane1 srca", ren_pa[1], VECS[r].pa1);
                chk("R5 lane1 srcb", ren_pb[1], VECS[r].pb1);
                chk("R3 lane1 dst", ren_pdst[1], VECS[r].pd1);
                chk("R5 lane1 old", ren_pold[1], VECS[r].po1);
            end
        end

        // R7: commit the first two renames, then R8: flush with a rename attempt
        drive(2'b00, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 5'd1, 6'd32, 1'b0);
        drive(2'b00, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 5'd4, 6'd33, 1'b0);
        drive(2'b11, 5'd5, 5'd0, 5'd0, 5'd6, 5'd0, 5'd0, 1'b0, 5'd0, 6'd0, 1'b1);
        chk("R8 rename refused during flush", ren_fire, 0);
        drive(2'b11, 5'd3, 5'd1, 5'd4, 5'd2, 5'd7, 5'd5, 1'b0, 5'd0, 6'd0, 1'b0);
        chk("R8 fire after flush", ren_fire, 1);
        chk("R7 committed map r1", ren_pa[0], 32);
        chk("R7 committed map r4", ren_pb[0], 33);
        chk("R8 rewound head lane0", ren_pdst[0], 34);
        chk("R8 old of r3", ren_pold[0], 3);
        chk("R8 squashed r7 restored", ren_pa[1], 7);
        chk("R8 flush-cycle rename left r5", ren_pb[1], 5);
        chk("R8 rewound head lane1", ren_pdst[1], 35);
        chk("R8 old of r2", ren_pold[1], 2);

        // R9: drain the pool; registers freed by commits come out last, in order
        for (int k = 0; k < 15; k++) begin
            drive(2'b11, 5'd10, 5'd0, 5'd0, 5'd10, 5'd0, 5'd0, 1'b0, 5'd0, 6'd0, 1'b0);
            chk("R9 drain fire", ren_fire, 1);
            chk("R9 drain lane0", ren_pdst[0], (k < 14) ? 36 + 2 * k : 1);
            chk("R9 drain lane1", ren_pdst[1], (k < 14) ? 37 + 2 * k : 4);
        end

        // R7: pool empty, commit frees r3's old register in the same cycle
        drive(2'b01, 5'd20, 5'd20, 5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 5'd3, 6'd34, 1'b0);
        chk("R7 freed reg not usable same cycle", ren_stall, 1);
        chk("R7 no fire on empty pool", ren_fire, 0);
        drive(2'b01, 5'd20, 5'd20, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 6'd0, 1'b0);
        chk("R7 fire next cycle", ren_fire, 1);
        chk("R9 freed reg reused", ren_pdst[0], 3);
        chk("R4 old of r20", ren_pold[0], 20);

        // R6: one free register, two-lane group is refused whole
        drive(2'b00, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 5'd2, 6'd35, 1'b0);
        drive(2'b11, 5'd21, 5'd0, 5'd0, 5'd22, 5'd0, 5'd0, 1'b0, 5'd0, 6'd0, 1'b0);
        chk("R6 stall on short pool", ren_stall, 1);
        chk("R6 no fire", ren_fire, 0);
        drive(2'b01, 5'd21, 5'd21, 5'd22, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 6'd0, 1'b0);
        chk("R6 single lane fits", ren_fire, 1);
        chk("R6 r21 untouched by refused group", ren_pa[0], 21);
        chk("R6 r22 untouched by refused group", ren_pb[0], 22);
        chk("R9 second freed reg", ren_pdst[0], 2);

        drive(2'b00, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 6'd0, 1'b0);
        finish_run();
    end
endmodule